// File: doc/BRIEF.md
# Serial Transmit Start and Frame-Sync Controller

This block decides the moment at which a synchronous serial transmitter launches each word, and it produces an optional periodic frame-sync pulse. All of its state advances only on cycles where the transmit clock enable is high. One such cycle is called a tick below. A four-bit start select picks the launch condition. The choices are a pending word in the holding register, the receiver's start strobe, a level on the frame-sync input, an edge on that input, or any change of it. Codes above seven never launch.

Once a launch condition is seen, an optional start delay of up to 255 ticks is counted before the one-tick start pulse is issued. After that the controller waits for the transfer-done flag. New launch conditions are ignored while the delay runs and while a word is in flight. A separate divider emits a one-tick frame-sync pulse every 2×(N+1) ticks. Setting N to zero switches this pulse off.

Top module: `tx_start_ctrl`

## Requirements
- R1: While reset is held low, and after it is released with all configuration at zero, `tx_start` and `fs_out` are low.
- R2: Code 0 (continuous): when idle with `thr_full` high, a start is issued on that tick. On a tick where `xfer_done` is high during a transfer and `thr_full` is high, the next start is issued on that same tick.
- R3: Code 1: a start follows a tick on which `rx_start` is high. Without the strobe, no start occurs.
- R4: Code 2 launches on a low synchronized frame-sync level. Code 3 launches on a high level.
- R5: Code 4 launches on a falling edge of the synchronized frame-sync input. Code 5 launches on a rising edge. The opposite edge does nothing.
- R6: Codes 6 and 7 both launch on any change of the synchronized frame-sync input.
- R7: Codes 8 to 15 never produce a start.
- R8: `fs_pin` passes through two flops clocked on ticks. An edge applied before tick a produces a start pulse visible after tick a+2, when the delay is zero.
- R9: With a delay value D, the start pulse comes D ticks later than with D=0. This also holds for code 1.
- R10: Launch conditions that occur while a delay is counting, or before `xfer_done` ends a transfer, are discarded.
- R11: `tx_start` is high for exactly one tick. When `tck_en` has gaps, the pulse spans the clocks up to the next tick.
- R12: With `cfg_period` equal to 0, `fs_out` stays low.
- R13: With `cfg_period` equal to N>0, `fs_out` is high for one tick and rises every 2×(N+1) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tck_en | input | 1 | Transmit clock enable; one tick per high cycle |
| fs_pin | input | 1 | Asynchronous frame-sync input |
| rx_start | input | 1 | Receiver start strobe |
| thr_full | input | 1 | Holding register contains a word to send |
| xfer_done | input | 1 | Current word has finished shifting |
| cfg_start_sel | input | 4 | Launch condition code |
| cfg_start_dly | input | 8 | Start delay in ticks |
| cfg_period | input | 8 | Frame-sync divider N |
| tx_start | output | 1 | Start-transmission pulse |
| fs_out | output | 1 | Generated frame-sync pulse |

## Verification
Every start code is driven with a frame-sync level that is held, one that moves in the triggering direction, and one that moves against it. This separates level modes from edge modes, and separates each edge direction from its opposite. The input-side codes, continuous and receiver-linked, are also run with their trigger absent. Latency is measured from the pin edge and from the receiver strobe at delays 0, 3 and 255, which exposes any missing or extra register stage. The divider is measured rise-to-rise at several N values, with and without gaps in the clock enable.

// File: rtl/txs_pkg.sv
`timescale 1ns/1ps
package txs_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_BUSY  = 2'd2
    } seq_state_e;

    typedef enum logic [3:0] {
        TRG_CONT   = 4'd0,
        TRG_RXLINK = 4'd1,
        TRG_LOW    = 4'd2,
        TRG_HIGH   = 4'd3,
        TRG_FALL   = 4'd4,
        TRG_RISE   = 4'd5,
        TRG_CHANGE = 4'd6,
        TRG_EDGE   = 4'd7
    } trig_code_e;

    typedef struct packed {
        logic s_meta;
        logic s_cur;
        logic s_prev;
    } fs_samp_t;

endpackage

// File: rtl/txs_fs_sync.sv
`timescale 1ns/1ps
module txs_fs_sync
    import txs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tck_en,
    input  logic fs_pin,
    output logic fs_level,
    output logic fs_rise,
    output logic fs_fall
);

    fs_samp_t samp_d, samp_q;

    always_comb begin
        samp_d = samp_q;
        if (tck_en) begin
            samp_d.s_meta = fs_pin;
            samp_d.s_cur  = samp_q.s_meta;
            samp_d.s_prev = samp_q.s_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= samp_d;
    end

    assign fs_level = samp_q.s_cur;
    assign fs_rise  = samp_q.s_cur & ~samp_q.s_prev;
    assign fs_fall  = ~samp_q.s_cur & samp_q.s_prev;

endmodule

// File: rtl/txs_trig_sel.sv
`timescale 1ns/1ps
module txs_trig_sel
    import txs_pkg::*;
#(
    parameter int unsigned SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             thr_full,
    input  logic             rx_start,
    input  logic             fs_level,
    input  logic             fs_rise,
    input  logic             fs_fall,
    output logic             trig
);

    localparam int unsigned NCODE = 2 ** SEL_W;

    logic [NCODE-1:0] cand;

    for (genvar c = 0; c < NCODE; c++) begin : g_code
        if (c == int'(TRG_CONT)) begin : g_cont
            assign cand[c] = thr_full;
        end else if (c == int'(TRG_RXLINK)) begin : g_rx
            assign cand[c] = rx_start;
        end else if (c == int'(TRG_LOW)) begin : g_low
            assign cand[c] = ~fs_level;
        end else if (c == int'(TRG_HIGH)) begin : g_high
            assign cand[c] = fs_level;
        end else if (c == int'(TRG_FALL)) begin : g_fall
            assign cand[c] = fs_fall;
        end else if (c == int'(TRG_RISE)) begin : g_rise
            assign cand[c] = fs_rise;
        end else if (c == int'(TRG_CHANGE) || c == int'(TRG_EDGE)) begin : g_any
            assign cand[c] = fs_rise | fs_fall;
        end else begin : g_rsvd
            assign cand[c] = 1'b0;
        end
    end

    assign trig = cand[sel];

endmodule

// File: rtl/txs_start_seq.sv
`timescale 1ns/1ps
module txs_start_seq
    import txs_pkg::*;
#(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tck_en,
    input  logic             trig,
    input  logic             xfer_done,
    input  logic [DLY_W-1:0] cfg_dly,
    output logic             tx_start,
    output logic             active
);

    typedef struct packed {
        seq_state_e       state;
        logic [DLY_W-1:0] cnt;
        logic             start;
    } seq_t;

    seq_t seq_d, seq_q;
    logic launch;

    always_comb begin
        seq_d  = seq_q;
        launch = 1'b0;
        if (tck_en) begin
            seq_d.start = 1'b0;
            unique case (seq_q.state)
                SEQ_IDLE: launch = 1'b1;
                SEQ_DELAY: begin
                    if (seq_q.cnt <= DLY_W'(1)) begin
                        seq_d.start = 1'b1;
                        seq_d.state = SEQ_BUSY;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
                SEQ_BUSY: begin
                    if (xfer_done) begin
                        seq_d.state = SEQ_IDLE;
                        launch      = 1'b1;
                    end
                end
                default: seq_d.state = SEQ_IDLE;
            endcase
            if (launch && trig) begin
                if (cfg_dly == '0) begin
                    seq_d.start = 1'b1;
                    seq_d.state = SEQ_BUSY;
                end else begin
                    seq_d.state = SEQ_DELAY;
                    seq_d.cnt   = cfg_dly;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SEQ_IDLE;
            seq_q.cnt   <= '0;
            seq_q.start <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tx_start = seq_q.start;
    assign active   = (seq_q.state != SEQ_IDLE);

endmodule

// File: rtl/txs_period_gen.sv
`timescale 1ns/1ps
module txs_period_gen #(
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tck_en,
    input  logic [PER_W-1:0] cfg_period,
    output logic             fs_out
);

    localparam int unsigned CNT_W = PER_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fs;
    } per_t;

    per_t per_d, per_q;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = {cfg_period, 1'b1};

    always_comb begin
        per_d = per_q;
        if (tck_en) begin
            per_d.fs = 1'b0;
            if (cfg_period == '0) begin
                per_d.cnt = '0;
            end else if (per_q.cnt >= last_cnt) begin
                per_d.cnt = '0;
                per_d.fs  = 1'b1;
            end else begin
                per_d.cnt = per_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_q <= '0;
        else        per_q <= per_d;
    end

    assign fs_out = per_q.fs;

endmodule

// File: rtl/tx_start_ctrl.sv
`timescale 1ns/1ps
module tx_start_ctrl #(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned DLY_W = 8,
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tck_en,
    input  logic             fs_pin,
    input  logic             rx_start,
    input  logic             thr_full,
    input  logic             xfer_done,
    input  logic [SEL_W-1:0] cfg_start_sel,
    input  logic [DLY_W-1:0] cfg_start_dly,
    input  logic [PER_W-1:0] cfg_period,
    output logic             tx_start,
    output logic             fs_out
);

    logic fs_level, fs_rise, fs_fall;
    logic trig;
    logic seq_active;

    txs_fs_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tck_en   (tck_en),
        .fs_pin   (fs_pin),
        .fs_level (fs_level),
        .fs_rise  (fs_rise),
        .fs_fall  (fs_fall)
    );

    txs_trig_sel #(.SEL_W(SEL_W)) u_trig (
        .sel      (cfg_start_sel),
        .thr_full (thr_full),
        .rx_start (rx_start),
        .fs_level (fs_level),
        .fs_rise  (fs_rise),
        .fs_fall  (fs_fall),
        .trig     (trig)
    );

    txs_start_seq #(.DLY_W(DLY_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tck_en    (tck_en),
        .trig      (trig),
        .xfer_done (xfer_done),
        .cfg_dly   (cfg_start_dly),
        .tx_start  (tx_start),
        .active    (seq_active)
    );

    txs_period_gen #(.PER_W(PER_W)) u_per (
        .clk        (clk),
        .rst_n      (rst_n),
        .tck_en     (tck_en),
        .cfg_period (cfg_period),
        .fs_out     (fs_out)
    );

endmodule

// File: rtl/tx_start_ctrl_chk.sv
`timescale 1ns/1ps
module tx_start_ctrl_chk #(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tck_en,
    input logic             rx_start,
    input logic             xfer_done,
    input logic [SEL_W-1:0] cfg_start_sel,
    input logic [PER_W-1:0] cfg_period,
    input logic             tx_start,
    input logic             fs_out,
    input logic             seq_active
);

    localparam int unsigned GAP_W = PER_W + 2;

    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] gap_exp;
    logic [PER_W-1:0] per_seen_q;
    logic             seen_q;

    assign gap_exp = GAP_W'({cfg_period, 1'b1}) + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q      <= '0;
            per_seen_q <= '0;
            seen_q     <= 1'b0;
        end else begin
            per_seen_q <= cfg_period;
            if (tck_en) begin
                if (fs_out)         gap_q <= GAP_W'(1);
                else if (!(&gap_q)) gap_q <= gap_q + 1'b1;
            end
            if (cfg_period != per_seen_q) seen_q <= 1'b0;
            else if (tck_en && fs_out)    seen_q <= 1'b1;
        end
    end

    AST_START_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start && tck_en && !xfer_done |=> !tx_start); // R11

    AST_RSVD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        tck_en && cfg_start_sel[SEL_W-1] && !seq_active |=> !tx_start); // R7

    AST_RX_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tck_en && cfg_start_sel == SEL_W'(1) && !rx_start && !seq_active |=> !tx_start); // R3

    AST_FS_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tck_en && cfg_period == '0 |=> !fs_out); // R12

    AST_FS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tck_en && fs_out && seen_q && cfg_period == per_seen_q |-> gap_q == gap_exp); // R13

endmodule

bind tx_start_ctrl tx_start_ctrl_chk #(.SEL_W(SEL_W), .PER_W(PER_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tck_en        (tck_en),
    .rx_start      (rx_start),
    .xfer_done     (xfer_done),
    .cfg_start_sel (cfg_start_sel),
    .cfg_period    (cfg_period),
    .tx_start      (tx_start),
    .fs_out        (fs_out),
    .seq_active    (seq_active)
);

// File: tb/tx_start_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_start_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tck_en = 1'b1;
    logic       fs_pin = 1'b0;
    logic       rx_start = 1'b0;
    logic       thr_full = 1'b0;
    logic       xfer_done = 1'b0;
    logic [3:0] cfg_start_sel = 4'd0;
    logic [7:0] cfg_start_dly = 8'd0;
    logic [7:0] cfg_period = 8'd0;
    logic       tx_start;
    logic       fs_out;

    int  checks = 0;
    int  errors = 0;
    bit  gate = 1'b0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    tx_start_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tck_en        (tck_en),
        .fs_pin        (fs_pin),
        .rx_start      (rx_start),
        .thr_full      (thr_full),
        .xfer_done     (xfer_done),
        .cfg_start_sel (cfg_start_sel),
        .cfg_start_dly (cfg_start_dly),
        .cfg_period    (cfg_period),
        .tx_start      (tx_start),
        .fs_out        (fs_out)
    );

    // {sel[3:0], fs before, fs after, expected start count}
    localparam logic [6:0] VEC [16] = '{
        {4'd2, 1'b1, 1'b0, 1'b1}, {4'd2, 1'b1, 1'b1, 1'b0},
        {4'd3, 1'b0, 1'b1, 1'b1}, {4'd3, 1'b0, 1'b0, 1'b0},
        {4'd4, 1'b1, 1'b0, 1'b1}, {4'd4, 1'b0, 1'b1, 1'b0},
        {4'd5, 1'b0, 1'b1, 1'b1}, {4'd5, 1'b1, 1'b0, 1'b0},
        {4'd6, 1'b0, 1'b1, 1'b1}, {4'd6, 1'b1, 1'b1, 1'b0},
        {4'd7, 1'b1, 1'b0, 1'b1}, {4'd7, 1'b0, 1'b1, 1'b1},
        {4'd8, 1'b0, 1'b1, 1'b0}, {4'd15, 1'b1, 1'b0, 1'b0},
        {4'd1, 1'b0, 1'b1, 1'b0}, {4'd0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] s);
        if (s >= 4'd8) return "R7";
        case (s)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
        tck_en = gate ? ~tck_en : 1'b1;
    endtask

    task automatic quiesce();
        cfg_start_sel = 4'd15;
        thr_full = 1'b0;
        rx_start = 1'b0;
        xfer_done = 1'b1;
        step();
        step();
        xfer_done = 1'b0;
        repeat (4) step();
    endtask

    task automatic count_starts(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (tx_start) cnt++;
        end
    endtask

    task automatic rx_latency(output int n);
        rx_start = 1'b1;
        step();
        rx_start = 1'b0;
        n = 1;
        while (!tx_start && n < 400) begin
            step();
            n++;
        end
    endtask

    task automatic fs_gap(output int n);
        int guard;
        bit prev;
        guard = 0;
        prev = fs_out;
        while (!(fs_out && !prev) && guard < 3000) begin
            prev = fs_out;
            step();
            guard++;
        end
        n = 0;
        prev = fs_out;
        step();
        n = 1;
        while (!(fs_out && !prev) && n < 3000) begin
            prev = fs_out;
            step();
            n++;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        int n;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 tx_start in reset", int'(tx_start), 0);
        chk("R1 fs_out in reset", int'(fs_out), 0);
        rst_n = 1'b1;
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (tx_start || fs_out) cnt++;
        end
        chk("R1 R12 quiet after reset", cnt, 0);

        // table of launch codes
        for (int v = 0; v < 16; v++) begin
            int c1, c2;
            quiesce();
            fs_pin = VEC[v][2];
            repeat (5) step();
            cfg_start_sel = VEC[v][6:3];
            count_starts(2, c1);
            fs_pin = VEC[v][1];
            count_starts(8, c2);
            chk(req_of(VEC[v][6:3]), c1 + c2, int'(VEC[v][0]));
        end

        // R2 continuous mode
        quiesce();
        cfg_start_sel = 4'd0;
        thr_full = 1'b1;
        step();
        chk("R2 start on pending word", int'(tx_start), 1);
        count_starts(6, cnt);
        chk("R10 no restart while busy", cnt, 0);
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        chk("R2 back-to-back on done", int'(tx_start), 1);
        thr_full = 1'b0;
        step();
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        count_starts(5, cnt);
        chk("R2 no start without word", cnt, 0);

        // R8 synchronizer latency
        quiesce();
        fs_pin = 1'b0;
        repeat (4) step();
        cfg_start_sel = 4'd5;
        step();
        fs_pin = 1'b1;
        n = 0;
        while (!tx_start && n < 20) begin
            step();
            n++;
        end
        chk("R8 pin-to-start latency", n, 3);

        // R9 start delay in receiver-linked mode
        quiesce();
        cfg_start_sel = 4'd1;
        cfg_start_dly = 8'd0;
        rx_latency(n);
        chk("R3 R9 strobe latency delay 0", n, 1);
        quiesce();
        cfg_start_sel = 4'd1;
        cfg_start_dly = 8'd3;
        rx_latency(n);
        chk("R9 strobe latency delay 3", n, 4);
        quiesce();
        cfg_start_sel = 4'd1;
        cfg_start_dly = 8'd255;
        rx_latency(n);
        chk("R9 strobe latency delay 255", n, 256);

        // R10 strobe during delay discarded
        quiesce();
        cfg_start_sel = 4'd1;
        cfg_start_dly = 8'd5;
        rx_start = 1'b1;
        step();
        rx_start = 1'b0;
        step();
        rx_start = 1'b1;
        step();
        rx_start = 1'b0;
        count_starts(14, cnt);
        chk("R10 single start despite strobe in delay", cnt, 1);
        cfg_start_dly = 8'd0;

        // R13 frame-sync period
        quiesce();
        cfg_period = 8'd3;
        fs_gap(n);
        chk("R13 gap N=3", n, 8);
        step();
        chk("R13 fs one tick wide", int'(fs_out), 0);
        cfg_period = 8'd1;
        fs_gap(n);
        chk("R13 gap N=1", n, 4);
        cfg_period = 8'd255;
        fs_gap(n);
        chk("R13 gap N=255", n, 512);
        cfg_period = 8'd0;
        step();
        step();
        cnt = 0;
        for (int i = 0; i < 600; i++) begin
            step();
            if (fs_out) cnt++;
        end
        chk("R12 no fs with N=0", cnt, 0);

        // R11 gapped clock enable
        gate = 1'b1;
        cfg_period = 8'd3;
        fs_gap(n);
        chk("R11 R13 gap N=3 gated enable", n, 16);
        cfg_period = 8'd0;
        quiesce();
        cfg_start_sel = 4'd1;
        rx_start = 1'b1;
        step();
        step();
        rx_start = 1'b0;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            if (tx_start) cnt++;
            step();
        end
        chk("R11 start spans one tick when gated", cnt, 2);
        gate = 1'b0;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule